// File: doc/BRIEF.md
# Ethernet Address Hash Generator

This block turns a 48-bit destination MAC address into a 15-bit index for an address-filter table. It does not compute a CRC. It reverses the bit order inside every address byte and then XORs fixed bit slices of the result together. In one of the two modes, each 9-bit slice is also bit-reversed before the XOR.

The requester presents the address together with a mode bit and pulses a valid strobe. One clock later the index appears on a registered output with its own valid flag. The table memory and the accept/reject decision belong to surrounding logic.

Top module: `mac_hash_gen`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and hash_o is 0.
- R2: Let T be the 48-bit value built from mac_i as follows. The first address byte is mac_i[47:40] and the last is mac_i[7:0]. Each byte keeps its position in T, but its bits are reversed, so T[8b+i] = mac_i[8b+7-i].
- R3: With mode_i = 0, hash bits [8:0] are {T[14:8], T[1:0]} XOR T[23:15] XOR T[32:24].
- R4: With mode_i = 0, hash bits [14:9] are T[7:2].
- R5: With mode_i = 1, hash bits [8:0] are r(T[14:6]) XOR r(T[23:15]) XOR r(T[32:24]). Here r() reverses all 9 bits of its argument.
- R6: With mode_i = 1, hash bits [14:9] are T[5:0].
- R7: valid_o is high in exactly the cycle after a cycle in which valid_i was sampled high. hash_o holds the index of the address and mode sampled in that same cycle.
- R8: While valid_i is low, hash_o keeps its last value, whatever mac_i and mode_i do.
- R9: mac_i[47:40] and mac_i[38:32] have no effect on the index in either mode.
- R10: The broadcast address (all ones) gives index 0x7FFF in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address strobe |
| mode_i | input | 1 | 0: plain slice fold, 1: reversed slice fold |
| mac_i | input | 48 | Destination MAC address, first byte in bits [47:40] |
| valid_o | output | 1 | Index valid, one cycle after valid_i |
| hash_o | output | 15 | Hash index |

## Verification
Three kinds of directed input check the fold structure:
- A single set bit walked across all 48 address positions, in both modes. Each step lights exactly the output bits that one address bit feeds, so a wrong slice offset, a missing byte reversal or a missing 9-bit reversal shows up at a distinct position.
- The broadcast and all-zero addresses, which check the XOR parity of the three slices.
- Addresses that differ only in the ignored bits, which separate real dependencies from bits that should be dropped.

Random addresses with random modes and gaps in the strobe exercise dense XOR cancellation and the hold behaviour between strobes.

// File: rtl/mac_hash_pkg.sv
package mac_hash_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 6;
  localparam int MAC_W   = BYTE_W * N_BYTES;
  localparam int SLICE_W = 9;
  localparam int HASH_W  = 15;
  localparam int SPAN_W  = 33;  // T bits that reach the hash

  typedef enum logic {
    HM_PLAIN = 1'b0,
    HM_REV   = 1'b1
  } hash_mode_e;

  function automatic logic [SLICE_W-1:0] rev_slice(input logic [SLICE_W-1:0] v);
    logic [SLICE_W-1:0] r;
    for (int i = 0; i < SLICE_W; i++) r[i] = v[SLICE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/mac_byte_reverse.sv
module mac_byte_reverse #(
  parameter int N_BYTES = 6,
  parameter int BYTE_W  = 8,
  localparam int W      = N_BYTES * BYTE_W
) (
  input  logic [W-1:0] mac_i,
  output logic [W-1:0] rev_o
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      assign rev_o[b*BYTE_W+i] = mac_i[b*BYTE_W+BYTE_W-1-i];
    end
  end
endmodule

// File: rtl/mac_hash_fold.sv
module mac_hash_fold
  import mac_hash_pkg::*;
#(
  parameter int N_SLICES = 3,
  parameter int BASE     = 6
) (
  input  logic [SPAN_W-1:0] t_i,
  input  hash_mode_e        mode_i,
  output logic [HASH_W-1:0] hash_o
);
  localparam int HI_W = HASH_W - SLICE_W;

  logic [SLICE_W-1:0] plain_s [N_SLICES];
  logic [SLICE_W-1:0] rev_s   [N_SLICES];
  logic [SLICE_W-1:0] plain_x, rev_x;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    assign plain_s[k] = t_i[BASE+k*SLICE_W +: SLICE_W];
    assign rev_s[k]   = rev_slice(plain_s[k]);
  end

  always_comb begin
    // plain mode: first term skips T[7:2], which go to the upper field
    plain_x = {t_i[14:8], t_i[1:0]};
    rev_x   = '0;
    for (int k = 1; k < N_SLICES; k++) plain_x ^= plain_s[k];
    for (int k = 0; k < N_SLICES; k++) rev_x ^= rev_s[k];
  end

  always_comb begin
    unique case (mode_i)
      HM_REV:  hash_o = {t_i[HI_W-1:0], rev_x};
      default: hash_o = {t_i[HI_W+1:2], plain_x};
    endcase
  end
endmodule

// File: rtl/mac_hash_gen.sv
module mac_hash_gen
  import mac_hash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [MAC_W-1:0]  mac_i,
  output logic              valid_o,
  output logic [HASH_W-1:0] hash_o
);
  logic [MAC_W-1:0]  t;
  logic [HASH_W-1:0] hash_d;
  logic              unused_hi;

  mac_byte_reverse #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W)) u_rev (
    .mac_i (mac_i),
    .rev_o (t)
  );

  assign unused_hi = ^t[MAC_W-1:SPAN_W];

  mac_hash_fold u_fold (
    .t_i    (t[SPAN_W-1:0]),
    .mode_i (hash_mode_e'(mode_i)),
    .hash_o (hash_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hash_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) hash_o <= hash_d;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(hash_o));
  // R4
  plain_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> (hash_o[9] == $past(mac_i[5]) && hash_o[14] == $past(mac_i[0])));
  // R6
  rev_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i) |=> (hash_o[9] == $past(mac_i[7]) && hash_o[14] == $past(mac_i[2])));
  // R10
  bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &mac_i) |=> &hash_o);
endmodule

// File: tb/mac_hash_gen_test.sv
`timescale 1ns/1ps
module mac_hash_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [47:0] mac_i = '0;
  logic        valid_o;
  logic [14:0] hash_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  mac_hash_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .mac_i(mac_i), .valid_o(valid_o), .hash_o(hash_o)
  );

  function automatic logic [8:0] r9(input logic [8:0] v);
    logic [8:0] r;
    for (int i = 0; i < 9; i++) r[i] = v[8-i];
    return r;
  endfunction

  function automatic logic [14:0] ref_hash(input logic [47:0] m, input logic md);
    logic [47:0] t;
    logic [8:0]  lo;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) t[8*b+i] = m[8*b+7-i];
    if (!md) begin
      lo = {t[14:8], t[1:0]} ^ t[23:15] ^ t[32:24];
      return {t[7:2], lo};
    end
    lo = r9(t[14:6]) ^ r9(t[23:15]) ^ r9(t[32:24]);
    return {t[5:0], lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one strobe, result checked at the following falling edge
  task automatic apply(input string req, input logic [47:0] m, input logic md);
    @(negedge clk_i);
    mac_i = m; mode_i = md; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " R7 valid"}, 32'(valid_o), 32'd1);
    chk(req, 32'(hash_o), 32'(ref_hash(m, md)));
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [14:0] h1;
    logic [47:0] m;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 valid", 32'(valid_o), 32'd0);
    chk("R1 hash", 32'(hash_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 idle", 32'(valid_o), 32'd0);

    // R10
    apply("R10 plain", '1, 1'b0);
    chk("R10 plain", 32'(hash_o), 32'h7fff);
    apply("R10 rev", '1, 1'b1);
    chk("R10 rev", 32'(hash_o), 32'h7fff);
    apply("R3 zero", '0, 1'b0);
    apply("R5 zero", '0, 1'b1);

    // R2 R3 R4 R5 R6: walking one
    for (int b = 0; b < 48; b++) begin
      apply("R2 R3 R4 walk", 48'd1 << b, 1'b0);
      apply("R2 R5 R6 walk", 48'd1 << b, 1'b1);
    end

    // R9: ignored address bits
    for (int k = 0; k < 20; k++) begin
      logic md;
      m  = {$urandom, $urandom};
      md = 1'($urandom);
      apply("R9 base", m, md);
      h1 = hash_o;
      m[47:40] = m[47:40] ^ 8'($urandom | 1);
      m[38:32] = m[38:32] ^ 7'($urandom);
      apply("R9 masked", m, md);
      chk("R9 ignored bits", 32'(hash_o), 32'(h1));
    end

    // R8: no strobe, inputs change
    for (int k = 0; k < 10; k++) begin
      apply("R8 load", {$urandom, $urandom}, 1'($urandom));
      h1 = hash_o;
      mac_i = {$urandom, $urandom}; mode_i = ~mode_i;
      @(negedge clk_i);
      chk("R8 hold", 32'(hash_o), 32'(h1));
      chk("R7 no strobe", 32'(valid_o), 32'd0);
    end

    // random addresses, random modes and gaps
    for (int k = 0; k < 300; k++) begin
      m = {$urandom, $urandom};
      apply(((k % 2) == 0) ? "R3 R4 random" : "R5 R6 random", m, 1'(k % 2));
      repeat ($urandom_range(0, 2)) @(negedge clk_i);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule